// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a single-word load or store, and the value that the base register takes if it is updated. It takes a base operand and an offset. The base operand is either a register value or the program counter. The offset is either a 12-bit unsigned immediate or a register value passed through a barrel shifter. A direction bit chooses whether the offset is added or subtracted. An indexing bit chooses between pre-index and post-index. A writeback bit requests a base update on pre-index forms.

The block is a single pipeline stage. A request presented with `req_valid` produces registered results one clock later, flagged by `out_valid`. The results are the effective address, the updated base value and a writeback enable for the register file. Between requests the outputs keep their last values. Register-indirect access is the degenerate case: a zero immediate offset with pre-index. Relative access sets `base_is_pc`.

Top module: `ls_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `wb_en`, `ea` and `new_base` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `req_valid` was sampled high.
- R3: With `off_is_reg`=0, the offset is `off_imm` zero-extended. `up`=1 adds the offset to the base and `up`=0 subtracts it. `new_base` is always base ± offset.
- R4: With `pre`=1 (pre-index), `ea` equals base ± offset, which is the same value as `new_base`.
- R5: With `pre`=0 (post-index), `ea` equals the unmodified base.
- R6: `wb_en` = 1 when `pre`=0, or when `pre`=1 and `wb`=1. Otherwise `wb_en` = 0.
- R7: With `base_is_pc`=1, the base is `pc_val` + 8 and `base_val` is ignored. With `base_is_pc`=0, the base is `base_val`.
- R8: With `off_is_reg`=1, the offset is `off_reg` shifted by `shift_amt` (1 to 31). The shift is chosen by `shift_kind`: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right.
- R9: A `shift_amt` of 0 has a special meaning for each kind. Logical left passes `off_reg` unchanged. Logical right gives 0 (a shift by 32). Arithmetic right fills every bit with bit 31 of `off_reg`. Rotate right is a one-bit rotate through `carry_in`: `carry_in` enters bit 31 and the low bit is dropped.
- R10: In a cycle after `req_valid` was low, `ea`, `new_base` and `wb_en` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base_is_pc | input | 1 | Use program counter as base |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Address of the current instruction |
| off_is_reg | input | 1 | Offset from register (1) or immediate (0) |
| off_imm | input | 12 | Unsigned immediate offset |
| off_reg | input | 32 | Register offset before shifting |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 5 | Shift amount |
| carry_in | input | 1 | Carry used by the zero-amount rotate |
| up | input | 1 | Add (1) or subtract (0) the offset |
| pre | input | 1 | Pre-index (1) or post-index (0) |
| wb | input | 1 | Writeback request for pre-index |
| out_valid | output | 1 | Results valid |
| ea | output | 32 | Effective address |
| new_base | output | 32 | Updated base value |
| wb_en | output | 1 | Base register writeback enable |

## Verification
All state in the block is the single output register stage, so a wrong captured value shows up on `ea`, `new_base` or `wb_en` in the cycle after the request. It stays visible there until the next request replaces it. If the valid flag is stuck or delayed, `out_valid` disagrees with the previous cycle's `req_valid` immediately. If a hold path is broken, the outputs change during idle cycles.

A shifter or adder fault affects only some combinations of shift kind, amount, direction and base source. For that reason, random requests are mixed with directed cases at shift amount zero, at full-width shifts and with the program counter as base. Each result is compared in the cycle it appears.

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 12,
  parameter int SHW      = $clog2(XLEN),
  parameter int PC_AHEAD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            base_is_pc,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] pc_val,
  input  logic            off_is_reg,
  input  logic [IMM_W-1:0] off_imm,
  input  logic [XLEN-1:0] off_reg,
  input  logic [1:0]      shift_kind,
  input  logic [SHW-1:0]  shift_amt,
  input  logic            carry_in,
  input  logic            up,
  input  logic            pre,
  input  logic            wb,
  output logic            out_valid,
  output logic [XLEN-1:0] ea,
  output logic [XLEN-1:0] new_base,
  output logic            wb_en
);

  localparam int PAD = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] barrel(
    input logic [XLEN-1:0] v,
    input logic [1:0]      k,
    input logic [SHW-1:0]  n,
    input logic            c
  );
    logic [2*XLEN-1:0] w;
    w = {v, v} >> n;
    case (k)
      2'd0:    barrel = v << n;
      2'd1:    barrel = (n == '0) ? '0 : (v >> n);
      2'd2:    barrel = (n == '0) ? {XLEN{v[XLEN-1]}} : XLEN'($signed(v) >>> n);
      default: barrel = (n == '0) ? {c, v[XLEN-1:1]} : w[XLEN-1:0];
    endcase
  endfunction

  logic [XLEN-1:0] base, offset, sum;

  assign base   = base_is_pc ? pc_val + XLEN'(PC_AHEAD) : base_val;
  assign offset = off_is_reg ? barrel(off_reg, shift_kind, shift_amt, carry_in)
                             : {{PAD{1'b0}}, off_imm};
  assign sum    = up ? base + offset : base - offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      new_base  <= '0;
      wb_en     <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        ea       <= pre ? sum : base;
        new_base <= sum;
        wb_en    <= !pre || wb;
      end
    end
  end

endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            base_is_pc,
  input logic [XLEN-1:0] base_val,
  input logic            pre,
  input logic            wb,
  input logic            out_valid,
  input logic [XLEN-1:0] ea,
  input logic [XLEN-1:0] new_base,
  input logic            wb_en
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R2

  AST_PRE_ADDR_IS_BASE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre) |=> (ea == new_base)); // R4

  AST_POST_ADDR_UNMODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pre && !base_is_pc) |=> (ea == $past(base_val))); // R5

  AST_WRITEBACK_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (wb_en == ($past(wb) || !$past(pre)))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(ea) && $stable(new_base) && $stable(wb_en))); // R10

endmodule

bind ls_addr_gen ls_addr_gen_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_is_pc(base_is_pc),
  .base_val(base_val), .pre(pre), .wb(wb), .out_valid(out_valid),
  .ea(ea), .new_base(new_base), .wb_en(wb_en)
);

// File: tb/ls_addr_gen_test.sv
`timescale 1ns/1ps
module ls_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, base_is_pc = 1'b0, off_is_reg = 1'b0;
  logic [31:0] base_val = '0, pc_val = '0, off_reg = '0;
  logic [11:0] off_imm = '0;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  shift_amt = '0;
  logic        carry_in = 1'b0, up = 1'b0, pre = 1'b0, wb = 1'b0;
  logic        out_valid, wb_en;
  logic [31:0] ea, new_base;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ls_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_is_pc(base_is_pc),
    .base_val(base_val), .pc_val(pc_val), .off_is_reg(off_is_reg),
    .off_imm(off_imm), .off_reg(off_reg), .shift_kind(shift_kind),
    .shift_amt(shift_amt), .carry_in(carry_in), .up(up), .pre(pre), .wb(wb),
    .out_valid(out_valid), .ea(ea), .new_base(new_base), .wb_en(wb_en)
  );

  function automatic logic [31:0] ref_off();
    logic [63:0] dbl;
    if (!off_is_reg) return {20'd0, off_imm};
    case (shift_kind)
      2'd0: return off_reg << shift_amt;
      2'd1: return (shift_amt == 0) ? 32'd0 : off_reg >> shift_amt;
      2'd2: begin
        if (shift_amt == 0) return off_reg[31] ? 32'hFFFF_FFFF : 32'd0;
        dbl = {{32{off_reg[31]}}, off_reg} >> shift_amt;
        return dbl[31:0];
      end
      default: begin
        if (shift_amt == 0) return {carry_in, off_reg[31:1]};
        return (off_reg >> shift_amt) | (off_reg << (6'd32 - 6'(shift_amt)));
      end
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_req(input string tag);
    logic [31:0] b, o, s;
    b = base_is_pc ? pc_val + 32'd8 : base_val;
    o = ref_off();
    s = up ? b + o : b - o;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk({tag, " valid R2"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " ea R4 R5"}, ea, pre ? s : b);
    chk({tag, " new_base R3"}, new_base, s);
    chk({tag, " wb_en R6"}, {31'd0, wb_en}, {31'd0, (!pre || wb)});
    @(negedge clk);
  endtask

  task automatic set_imm(input logic [31:0] bv, input logic [11:0] im,
                         input logic u, input logic p, input logic w);
    base_is_pc = 0; off_is_reg = 0; base_val = bv; off_imm = im;
    up = u; pre = p; wb = w;
  endtask

  task automatic set_reg(input logic [31:0] bv, input logic [31:0] r,
                         input logic [1:0] k, input logic [4:0] n, input logic c);
    base_is_pc = 0; off_is_reg = 1; base_val = bv; off_reg = r;
    shift_kind = k; shift_amt = n; carry_in = c; up = 1; pre = 1; wb = 0;
  endtask

  initial begin
    logic [31:0] hold_ea, hold_nb;
    void'($urandom(32'h1234_5678));
    @(negedge clk);
    chk("reset out_valid R1", {31'd0, out_valid}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("reset ea R1", ea, 32'd0);
    chk("reset new_base R1", new_base, 32'd0);
    chk("reset wb_en R1", {31'd0, wb_en}, 32'd0);
    @(negedge clk);

    set_imm(32'h0000_1000, 12'h000, 1, 1, 0); run_req("indirect R4");
    set_imm(32'h0000_2000, 12'h00C, 1, 1, 0); run_req("imm add R3");
    set_imm(32'h0000_3000, 12'h004, 0, 1, 1); run_req("pre dec wb R6");
    set_imm(32'h0000_4000, 12'hFFF, 0, 0, 0); run_req("post sub R5");
    set_imm(32'h0000_0000, 12'h001, 0, 1, 0); run_req("wrap R3");
    set_reg(32'h0000_0100, 32'h0000_0011, 2'd0, 5'd1, 0); run_req("lsl1 R8");
    set_reg(32'h0, 32'h8000_0001, 2'd1, 5'd31, 0); run_req("lsr31 R8");
    set_reg(32'h0, 32'h8000_0000, 2'd2, 5'd4, 0); run_req("asr4 R8");
    set_reg(32'h0, 32'h0000_00F1, 2'd3, 5'd4, 0); run_req("ror4 R8");
    set_reg(32'h10, 32'h1234_5678, 2'd0, 5'd0, 0); run_req("lsl0 R9");
    set_reg(32'h10, 32'hFFFF_FFFF, 2'd1, 5'd0, 0); run_req("lsr0 R9");
    set_reg(32'h10, 32'h8000_0000, 2'd2, 5'd0, 0); run_req("asr0 R9");
    set_reg(32'h0, 32'h0000_0003, 2'd3, 5'd0, 1); run_req("rrx c1 R9");
    set_reg(32'h0, 32'h0000_0003, 2'd3, 5'd0, 0); run_req("rrx c0 R9");
    set_imm(32'hDEAD_BEEF, 12'h010, 1, 1, 0); base_is_pc = 1;
    pc_val = 32'h0000_8000; run_req("pc base R7");
    set_imm(32'h0, 12'h020, 0, 0, 0); base_is_pc = 1;
    pc_val = 32'h0000_0000; run_req("pc post R7");

    hold_ea = ea; hold_nb = new_base;
    set_imm(32'hCAFE_0000, 12'h123, 1, 1, 1);
    repeat (3) @(posedge clk); #1;
    chk("hold valid R2", {31'd0, out_valid}, 32'd0);
    chk("hold ea R10", ea, hold_ea);
    chk("hold new_base R10", new_base, hold_nb);
    @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      base_is_pc = ($urandom % 4) == 0;
      base_val   = $urandom;
      pc_val     = $urandom & 32'hFFFF_FFFC;
      off_is_reg = $urandom % 2;
      off_imm    = 12'($urandom);
      off_reg    = $urandom;
      shift_kind = 2'($urandom);
      shift_amt  = (($urandom % 4) == 0) ? 5'd0 : 5'($urandom);
      carry_in   = $urandom % 2;
      up = $urandom % 2; pre = $urandom % 2; wb = $urandom % 2;
      run_req("random R3 R8");
      if (($urandom % 5) == 0) @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule